// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits between the write-strobe logic of a byte-wide nonvolatile memory and its programming path. It watches every completed write (address and data). From that stream it picks out the short command strings that software uses to switch write protection on or off. It keeps the protection flag, and for each ordinary data write it decides whether the byte may be committed. It also decides whether the internal programming timer should start, so that status-polling reads apply while that timer runs.

While protection is off, ordinary writes pass straight through. While it is on, a data write is committed only when it belongs to a burst that began with the three-write unlock string. Any other write is swallowed: nothing is stored, but the timer still starts. Command bytes are consumed by the detector and are never offered for storage. Successive command writes, and successive writes of an unlocked burst, must each arrive within a load window of the previous one. Otherwise the detector falls back to idle.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset, `protect_on` equals the parameter `PROTECT_INIT` (default 0, unprotected), and `wr_accept` and `timer_start` are low.
- R2: With protection off, a write that does not begin a command string produces a one-cycle pulse on both `wr_accept` and `timer_start` in the cycle after the strobe.
- R3: The unlock string is three writes in this order: data 0xAA to address 0x5555, data 0x55 to address 0x2AAA, data 0xA0 to address 0x5555. Completing it sets `protect_on` and pulses `timer_start` once. None of its three writes pulses `wr_accept`.
- R4: With protection on, a write outside an unlocked burst pulses `timer_start` but never `wr_accept`.
- R5: After the unlock string, each following write is accepted for as long as every write arrives no more than `LOAD_WINDOW` clock cycles after the previous one. A longer gap ends the burst.
- R6: The lock-release string is six writes: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x20/0x5555 (data/address). Completing it clears `protect_on` and pulses `timer_start` once. None of its writes pulses `wr_accept`.
- R7: A write that does not match the next expected step of a partly received string returns the detector to idle. That write is then handled as an ordinary write (accepted only when protection is off), and the earlier prefix bytes are discarded.
- R8: A gap longer than `LOAD_WINDOW` cycles between two writes of a command string abandons the string. The next write is then judged from idle.
- R9: Command matching compares only address bits [14:0]. Address bits above bit 14 have no effect on recognition.
- R10: `protect_on` changes only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle pulse marking a completed write strobe |
| wr_addr | input | ADDR_W | Address latched with the write |
| wr_data | input | 8 | Data byte latched with the write |
| wr_accept | output | 1 | Pulse: commit this write's byte to the array |
| timer_start | output | 1 | Pulse: start the internal programming timer |
| protect_on | output | 1 | Current write-protection state |

## Verification
Assertions check on every cycle that an accept pulse always comes with a timer pulse and follows a strobe. They also check that a protected accept happens only inside an open burst, that entering a partial command state emits nothing, that the flag moves only after a strobe, and that the window counter stays in range. Only the directed scenarios can show that the exact byte strings are recognised in order, that aborted prefixes and gaps are handled, and that burst expiry falls at the window length. The same goes for ignoring the upper address bits, because these depend on particular data and address values.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam int CMD_AW   = 15;
    localparam int NUM_KEYS = 5;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_K1   = 3'd1,
        SEQ_K2   = 3'd2,
        SEQ_PRE  = 3'd3,
        SEQ_K1B  = 3'd4,
        SEQ_K2B  = 3'd5,
        SEQ_OPEN = 3'd6
    } seq_e;

    // key indices
    localparam int KEY_A   = 0;
    localparam int KEY_B   = 1;
    localparam int KEY_ON  = 2;
    localparam int KEY_PRE = 3;
    localparam int KEY_OFF = 4;

    function automatic logic [CMD_AW-1:0] key_addr(input int idx);
        return (idx == KEY_B) ? 15'h2AAA : 15'h5555;
    endfunction

    function automatic logic [7:0] key_data(input int idx);
        case (idx)
            KEY_A:   return 8'hAA;
            KEY_B:   return 8'h55;
            KEY_ON:  return 8'hA0;
            KEY_PRE: return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

    typedef struct packed {
        seq_e seq;
        logic protect;
        logic accept;
        logic timer;
    } guard_st;

endpackage

// File: rtl/wpg_key_match.sv
module wpg_key_match
    import wpg_pkg::*;
(
    input  logic [CMD_AW-1:0]   addr_lo,
    input  logic [7:0]          data,
    output logic [NUM_KEYS-1:0] hit
);

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        assign hit[k] = (addr_lo == key_addr(k)) && (data == key_data(k));
    end

endmodule

// File: rtl/wpg_load_window.sv
module wpg_load_window #(
    parameter int LOAD_WINDOW = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic strobe,
    output logic expire
);

    localparam int GW = $clog2(LOAD_WINDOW + 1);
    localparam logic [GW-1:0] LAST = GW'(LOAD_WINDOW - 1);

    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d  = gap_q;
        expire = 1'b0;
        if (!active || strobe) begin
            gap_d = '0;
        end else if (gap_q == LAST) begin
            expire = 1'b1;
            gap_d  = '0;
        end else begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= LAST);

    p_gap_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> gap_q == '0);

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wpg_pkg::*;
#(
    parameter int   ADDR_W       = 19,
    parameter int   LOAD_WINDOW  = 30000,
    parameter logic PROTECT_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_accept,
    output logic              timer_start,
    output logic              protect_on
);

    guard_st cur_q, nxt_d;
    logic [NUM_KEYS-1:0] hit;
    logic expire;
    logic data_wr;

    wpg_key_match u_match (
        .addr_lo (wr_addr[CMD_AW-1:0]),
        .data    (wr_data),
        .hit     (hit)
    );

    wpg_load_window #(.LOAD_WINDOW(LOAD_WINDOW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (cur_q.seq != SEQ_IDLE),
        .strobe (wr_valid),
        .expire (expire)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.accept = 1'b0;
        nxt_d.timer  = 1'b0;
        data_wr      = 1'b0;
        if (wr_valid) begin
            case (cur_q.seq)
                SEQ_IDLE: begin
                    if (hit[KEY_A]) nxt_d.seq = SEQ_K1;
                    else            data_wr   = 1'b1;
                end
                SEQ_K1, SEQ_K1B: begin
                    if (hit[KEY_B]) begin
                        nxt_d.seq = (cur_q.seq == SEQ_K1) ? SEQ_K2 : SEQ_K2B;
                    end else begin
                        nxt_d.seq = SEQ_IDLE;
                        data_wr   = 1'b1;
                    end
                end
                SEQ_K2: begin
                    if (hit[KEY_ON]) begin
                        nxt_d.seq     = SEQ_OPEN;
                        nxt_d.protect = 1'b1;
                        nxt_d.timer   = 1'b1;
                    end else if (hit[KEY_PRE]) begin
                        nxt_d.seq = SEQ_PRE;
                    end else begin
                        nxt_d.seq = SEQ_IDLE;
                        data_wr   = 1'b1;
                    end
                end
                SEQ_PRE: begin
                    if (hit[KEY_A]) begin
                        nxt_d.seq = SEQ_K1B;
                    end else begin
                        nxt_d.seq = SEQ_IDLE;
                        data_wr   = 1'b1;
                    end
                end
                SEQ_K2B: begin
                    nxt_d.seq = SEQ_IDLE;
                    if (hit[KEY_OFF]) begin
                        nxt_d.protect = 1'b0;
                        nxt_d.timer   = 1'b1;
                    end else begin
                        data_wr = 1'b1;
                    end
                end
                SEQ_OPEN: data_wr = 1'b1;
                default: begin
                    nxt_d.seq = SEQ_IDLE;
                    data_wr   = 1'b1;
                end
            endcase
            if (data_wr) begin
                nxt_d.timer  = 1'b1;
                nxt_d.accept = !cur_q.protect || (cur_q.seq == SEQ_OPEN);
            end
        end else if (expire) begin
            nxt_d.seq = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.seq     <= SEQ_IDLE;
            cur_q.protect <= PROTECT_INIT;
            cur_q.accept  <= 1'b0;
            cur_q.timer   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_accept   = cur_q.accept;
    assign timer_start = cur_q.timer;
    assign protect_on  = cur_q.protect;

    p_accept_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> $past(wr_valid));

    p_accept_starts_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> timer_start);

    p_locked_accept_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && protect_on) |-> cur_q.seq == SEQ_OPEN);

    p_prefix_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid) && cur_q.seq != SEQ_IDLE && cur_q.seq != SEQ_OPEN)
            |-> (!wr_accept && !timer_start));

    p_flag_moves_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(protect_on) |-> $past(wr_valid));

    p_enable_opens_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect_on) |-> (cur_q.seq == SEQ_OPEN && timer_start));

    p_addr_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$isunknown(wr_addr));

endmodule

// File: tb/wp_seq_guard_test.sv
`timescale 1ns/100ps
module wp_seq_guard_test;

    localparam int AW  = 19;
    localparam int WIN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_accept, timer_start, protect_on;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wp_seq_guard #(.ADDR_W(AW), .LOAD_WINDOW(WIN), .PROTECT_INIT(1'b0)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_accept   (wr_accept),
        .timer_start (timer_start),
        .protect_on  (protect_on)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one write strobe; samples the registered response after it
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int exp_acc, input int exp_tim, input string tag);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk({tag, " accept"}, int'(wr_accept), exp_acc);
        chk({tag, " timer"},  int'(timer_start), exp_tim);
    endtask

    task automatic t_reset;
        chk("R1 protect after reset", int'(protect_on), 0);
        chk("R1 accept after reset", int'(wr_accept), 0);
        chk("R1 timer after reset", int'(timer_start), 0);
    endtask

    task automatic t_plain;
        wr(19'h01234, 8'h3C, 1, 1, "R2 plain write");
        @(negedge clk);
        chk("R2 accept is one pulse", int'(wr_accept), 0);
        chk("R2 timer is one pulse", int'(timer_start), 0);
    endtask

    task automatic t_enable_burst;
        wr(19'h05555, 8'hAA, 0, 0, "R3 unlock byte 1");
        wr(19'h02AAA, 8'h55, 0, 0, "R3 unlock byte 2");
        wr(19'h05555, 8'hA0, 0, 1, "R3 unlock byte 3");
        chk("R3 protect set", int'(protect_on), 1);
        idle(3);
        wr(19'h00400, 8'h11, 1, 1, "R5 burst write 1");
        idle(WIN - 2);
        wr(19'h00401, 8'h22, 1, 1, "R5 burst write in window");
        idle(WIN + 20);
        wr(19'h00402, 8'h33, 0, 1, "R5 write after burst ends");
    endtask

    task automatic t_locked;
        wr(19'h00100, 8'h5A, 0, 1, "R4 locked write");
        chk("R4 protect stays", int'(protect_on), 1);
    endtask

    task automatic t_abort_locked;
        wr(19'h05555, 8'hAA, 0, 0, "R7 prefix byte locked");
        wr(19'h00100, 8'h12, 0, 1, "R7 mismatch while locked");
        wr(19'h00200, 8'h34, 0, 1, "R7 no burst after abort");
    endtask

    task automatic t_disable;
        wr(19'h05555, 8'hAA, 0, 0, "R6 release byte 1");
        wr(19'h02AAA, 8'h55, 0, 0, "R6 release byte 2");
        wr(19'h05555, 8'h80, 0, 0, "R6 release byte 3");
        wr(19'h05555, 8'hAA, 0, 0, "R6 release byte 4");
        wr(19'h02AAA, 8'h55, 0, 0, "R6 release byte 5");
        wr(19'h05555, 8'h20, 0, 1, "R6 release byte 6");
        chk("R6 protect cleared", int'(protect_on), 0);
        wr(19'h00300, 8'h99, 1, 1, "R6 write after release");
    endtask

    task automatic t_abort_open;
        wr(19'h05555, 8'hAA, 0, 0, "R7 prefix byte 1");
        wr(19'h02AAA, 8'h55, 0, 0, "R7 prefix byte 2");
        wr(19'h00123, 8'h77, 1, 1, "R7 mismatch unlocked");
        chk("R7 protect unchanged", int'(protect_on), 0);
    endtask

    task automatic t_gap;
        wr(19'h05555, 8'hAA, 0, 0, "R8 byte 1");
        wr(19'h02AAA, 8'h55, 0, 0, "R8 byte 2");
        idle(WIN + 20);
        wr(19'h05555, 8'hA0, 1, 1, "R8 late third byte is data");
        chk("R8 protect not set", int'(protect_on), 0);
    endtask

    task automatic t_upper;
        wr(19'h45555, 8'hAA, 0, 0, "R9 unlock high bits 1");
        idle(5);
        wr(19'h72AAA, 8'h55, 0, 0, "R9 unlock high bits 2");
        idle(5);
        wr(19'h1D555, 8'hA0, 0, 1, "R9 unlock high bits 3");
        chk("R9 protect set", int'(protect_on), 1);
        wr(19'h00010, 8'h01, 1, 1, "R9 burst accepted");
        idle(WIN + 20);
        wr(19'h7D555, 8'hAA, 0, 0, "R9 release 1");
        wr(19'h3AAAA, 8'h55, 0, 0, "R9 release 2");
        wr(19'h25555, 8'h80, 0, 0, "R9 release 3");
        wr(19'h0D555, 8'hAA, 0, 0, "R9 release 4");
        wr(19'h4AAAA, 8'h55, 0, 0, "R9 release 5");
        wr(19'h6D555, 8'h20, 0, 1, "R9 release 6");
        chk("R9 protect cleared", int'(protect_on), 0);
        chk("R10 protect stable when idle", int'(protect_on), 0);
        idle(4);
        chk("R10 protect still clear", int'(protect_on), 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_enable_burst();
        t_locked();
        t_abort_locked();
        t_disable();
        t_abort_open();
        t_gap();
        t_upper();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule